// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets clocked logic use a 2048-word by 8-bit asynchronous static RAM that has one shared data bus and three active-low controls: chip select, output enable and write enable. A client offers one request at a time through a valid/ready handshake. Each request carries an 11-bit word address, a write flag and a write byte. The controller then runs the matching pin sequence on the memory and reports completion with a single-cycle done pulse. For a read, that pulse comes with the returned byte.

The analogue limits of the memory are given in nanoseconds: address-to-data, output-enable-to-data, write-pulse width, data setup, read cycle and write cycle. The clock period is a parameter too. From these the controller works out whole-cycle wait counts, rounding each one up and never letting it drop below one cycle. All memory-side pins come from registers. The shared data bus appears as separate outgoing data, driver enable and incoming data, so a pad ring or a testbench can close the tristate. Output enable stays high for the whole of a write. The data driver is on only while a write is under way. One dead cycle follows every read, so the memory's outputs are off before the next request is accepted.

Top module: `asram_ctrl`

## Requirements
- R1: In the first cycle after reset, chip select, output enable and write enable are all 1, the data driver is off, `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the operation and its recovery are over, and it is 0 whenever chip select is 0.
- R3: During a read, chip select and output enable are 0, write enable is 1, the driver is off, and `mem_addr` holds the requested address for every cycle that chip select is 0.
- R4: A read keeps chip select and output enable at 0 for the largest of ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS) and ceil(T_RC_NS/CLK_PERIOD_NS) cycles, which is 14 at the defaults. The data bus is sampled at the edge that ends this window. `rsp_done` is 1 in the cycle after that edge, with `rsp_rdata` equal to the stored word at the address.
- R5: During a write, chip select and write enable are 0 and output enable is 1. The driver is on and presents the request byte. Write enable stays 0 for the larger of ceil(T_WP_NS/CLK_PERIOD_NS) and ceil(T_DS_NS/CLK_PERIOD_NS) cycles, which is 8 at the defaults.
- R6: For exactly one cycle after write enable and chip select return to 1, the driver stays on with the same byte. The cycle after that, the driver is off.
- R7: A write holds `mem_addr` from acceptance until `rsp_done`. `rsp_done` is 1 no earlier than ceil(T_WC_NS/CLK_PERIOD_NS) cycles after acceptance, which is 14 at the defaults.
- R8: In the cycle where a read's `rsp_done` is 1, `req_ready` is 0 and all three controls are 1. `req_ready` returns to 1 one cycle later.
- R9: The driver is never on while output enable is 0.
- R10: `rsp_done` is a one-cycle pulse for every completed request. `rsp_rdata` changes only in a cycle where a read completes and is left unchanged by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 11 | Word address of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 11 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the shared data bus |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 8 | Byte seen on the shared data bus |

## Verification
The bench uses the default build: a 5 ns clock with 70 ns access and cycle limits, 35 ns output-enable access, a 40 ns write pulse and 30 ns data setup. These give a 14-cycle read window, an 8-cycle write pulse and a 5-cycle tail after the write hold cycle. Because every window is many cycles long, an off-by-one in any counter shifts an exactly predicted done cycle and is caught. The bus model counts the low time of each control and the data stability before write enable rises. When output enable is high it returns a fixed non-memory byte, so a sample taken outside the read window shows up as wrong data. Back-to-back reads and writes at address 0, address 2047 and all-zero and all-one bytes exercise the turnaround cycle and the data-hold cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WPULSE,
    ST_WHOLD,
    ST_WTAIL
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pin_cmd_t;

  // Whole cycles covering a nanosecond limit, never fewer than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels that belong to each sequencer state.
  function automatic pin_cmd_t pins_for(input seq_state_t s);
    pin_cmd_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    case (s)
      ST_RD:     begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
      ST_WHOLD:  p.drive = 1'b1;
      default:   ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
module asram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 14,
  parameter int WP_CYC  = 8,
  parameter int REC_CYC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             req_ready,
  output seq_state_t       state_nxt,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             fin_rd,
  output logic             fin_wr
);

  localparam int TAIL_LOAD = (REC_CYC > 1) ? REC_CYC - 2 : 0;
  localparam bit HAS_TAIL  = (REC_CYC > 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    state_nxt = state;
    accept    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    fin_rd    = 1'b0;
    fin_wr    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_nxt = ST_WPULSE;
            tmr_val   = CNT_W'(WP_CYC - 1);
          end else begin
            state_nxt = ST_RD;
            tmr_val   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (tmr_expired) begin
          state_nxt = ST_TURN;
          fin_rd    = 1'b1;
        end
      end
      ST_TURN: state_nxt = ST_IDLE;
      ST_WPULSE: begin
        if (tmr_expired) state_nxt = ST_WHOLD;
      end
      ST_WHOLD: begin
        if (HAS_TAIL) begin
          state_nxt = ST_WTAIL;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(TAIL_LOAD);
        end else begin
          state_nxt = ST_IDLE;
          fin_wr    = 1'b1;
        end
      end
      ST_WTAIL: begin
        if (tmr_expired) begin
          state_nxt = ST_IDLE;
          fin_wr    = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/asram_pin_drv.sv
`timescale 1ns/1ps
module asram_pin_drv
  import asram_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state_nxt,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          fin_rd,
  input  logic          fin_wr,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);

  pin_cmd_t cmd;
  assign cmd = pins_for(state_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      mem_ce_n  <= cmd.ce_n;
      mem_oe_n  <= cmd.oe_n;
      mem_we_n  <= cmd.we_n;
      mem_dq_oe <= cmd.drive;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_done <= fin_rd | fin_wr;
      if (fin_rd) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 11,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 70,
  parameter int T_WP_NS       = 40,
  parameter int T_DS_NS       = 30,
  parameter int T_WC_NS       = 70
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int RD_CYC  = int'(umax(umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                                     ns_to_cyc(T_RC_NS, CLK_PERIOD_NS)));
  localparam int WP_CYC  = int'(umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)));
  localparam int WC_CYC  = int'(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = (WC_CYC - WP_CYC > 1) ? WC_CYC - WP_CYC : 1;
  localparam int MAX_CYC = int'(umax(umax(RD_CYC, WP_CYC), REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t       state_nxt;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             fin_rd;
  logic             fin_wr;

  asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_seq #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .state_nxt   (state_nxt),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .fin_rd      (fin_rd),
    .fin_wr      (fin_wr)
  );

  asram_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .fin_rd     (fin_rd),
    .fin_wr     (fin_wr),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int RD_CYC = 14,
  parameter int WP_CYC = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [DW-1:0] rsp_rdata,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);

  logic [15:0] w_low_cnt;
  logic [15:0] g_low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_low_cnt <= '0;
      g_low_cnt <= '0;
    end else begin
      w_low_cnt <= mem_we_n ? 16'd0 : w_low_cnt + 16'd1;
      g_low_cnt <= mem_oe_n ? 16'd0 : g_low_cnt + 16'd1;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_done)); // R1
  AST_READY_LOW_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
  AST_READ_ACCESS_LONG: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (g_low_cnt >= 16'(RD_CYC))); // R4
  AST_WRITE_PULSE_LONG: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (w_low_cnt >= 16'(WP_CYC))); // R5
  AST_G_HIGH_WRITING: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_TURN_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> !req_ready); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10
  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> rsp_done); // R10

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW     (AW),
  .DW     (DW),
  .RD_CYC (RD_CYC),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int AW     = 11;
  localparam int DW     = 8;
  localparam int DEPTH  = 1 << AW;
  localparam int RD_EXP = 14;  // ceil(70/5)
  localparam int WP_EXP = 8;   // ceil(40/5)
  localparam int DS_EXP = 6;   // ceil(30/5)
  localparam int WC_EXP = 14;  // ceil(70/5)

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_write;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n;
  logic          mem_oe_n;
  logic          mem_we_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int n_chk  = 0;
  int n_fail = 0;

  logic [DW-1:0] mem_model [DEPTH];
  logic [DW-1:0] sb [DEPTH];

  always #2.5 clk = ~clk;

  asram_ctrl dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model: drives the word only with select low, write high, output enable low.
  assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ? mem_model[mem_addr] : 8'hC3;

  int            w_run  = 0;
  int            ds_run = 0;
  int            g_run  = 0;
  logic          prev_we_n = 1'b1;
  logic          prev_oe_n = 1'b1;
  logic [DW-1:0] prev_dq   = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R9 bus contention", 1, 0);
      if (!mem_we_n && !mem_ce_n) begin
        w_run++;
        if (mem_dq_oe && mem_dq_out == prev_dq) ds_run++;
        else ds_run = 1;
      end
      if (!mem_oe_n && !mem_ce_n) g_run++;
      if (!prev_we_n && mem_we_n) begin
        chk(w_run >= WP_EXP, "R5 write pulse width", w_run, WP_EXP);
        chk(ds_run >= DS_EXP, "R5 data setup", ds_run, DS_EXP);
        chk(mem_dq_oe && mem_dq_out == prev_dq, "R6 data hold", int'(mem_dq_out), int'(prev_dq));
        mem_model[mem_addr] = mem_dq_out;
        w_run  = 0;
        ds_run = 0;
      end
      if (!prev_oe_n && mem_oe_n) begin
        chk(g_run >= RD_EXP, "R4 read access time", g_run, RD_EXP);
        g_run = 0;
      end
    end
    prev_we_n = mem_we_n;
    prev_oe_n = mem_oe_n;
    prev_dq   = mem_dq_out;
  end

  task automatic t_reset();
    rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle pins",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    chk(req_ready && !rsp_done, "R1 ready/done", {req_ready, rsp_done}, 2'b10);
  endtask

  task automatic run_read(input logic [AW-1:0] a);
    logic [DW-1:0] exp_d;
    logic [DW-1:0] old_rd;
    int            n;
    exp_d = sb[a];
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5A;
    while (!req_ready) @(negedge clk);
    old_rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R3 read pins",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    chk(mem_addr == a, "R3 read address", int'(mem_addr), int'(a));
    chk(!req_ready, "R2 busy during read", int'(req_ready), 0);
    chk(rsp_rdata == old_rd, "R10 rdata held during read", int'(rsp_rdata), int'(old_rd));
    n = 0;
    while (!rsp_done && n < 100) begin
      @(negedge clk);
      n++;
      if (!rsp_done && mem_addr != a) chk(1'b0, "R3 address moved", int'(mem_addr), int'(a));
    end
    chk(n == RD_EXP, "R4 read latency", n, RD_EXP);
    chk(rsp_rdata == exp_d, "R4 read data", int'(rsp_rdata), int'(exp_d));
    chk(!req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R8 turnaround cycle",
        {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'b0111);
    @(negedge clk);
    chk(!rsp_done, "R10 done single cycle", int'(rsp_done), 0);
    chk(req_ready, "R8 ready after turnaround", int'(req_ready), 1);
  endtask

  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] old_rd;
    int            n;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    old_rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe, "R5 write pins",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
    chk(mem_dq_out == d, "R5 write data", int'(mem_dq_out), int'(d));
    chk(!req_ready, "R2 busy during write", int'(req_ready), 0);
    n = 0;
    while (!rsp_done && n < 100) begin
      @(negedge clk);
      n++;
      if (n == WP_EXP) begin
        chk(mem_we_n && mem_ce_n && mem_dq_oe && mem_dq_out == d, "R6 hold cycle",
            {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b111);
      end
      if (n == WP_EXP + 1) begin
        chk(!mem_dq_oe, "R6 driver off after hold", int'(mem_dq_oe), 0);
      end
      if (!rsp_done && mem_addr != a) chk(1'b0, "R7 address moved", int'(mem_addr), int'(a));
    end
    chk(n == WC_EXP, "R7 write cycle length", n, WC_EXP);
    chk(rsp_rdata == old_rd, "R10 rdata unchanged by write", int'(rsp_rdata), int'(old_rd));
    sb[a] = d;
    @(negedge clk);
    chk(!rsp_done, "R10 done single cycle", int'(rsp_done), 0);
  endtask

  task automatic t_corners();
    run_write(11'd0, 8'h00);
    run_write(11'h7FF, 8'hFF);
    run_read(11'd0);
    run_read(11'h7FF);
    run_write(11'd0, 8'hA5);
    run_read(11'd0);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 341 + 17);
      run_read(a);
      run_write(a, DW'(i * 37 + 9));
      run_read(a);
    end
  endtask

  task automatic t_untouched();
    run_read(11'd1000);
    run_read(11'd1001);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_model[i] = DW'(i * 7 + 3);
      sb[i]        = DW'(i * 7 + 3);
    end
    t_reset();
    t_untouched();
    t_corners();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule